// File: doc/BRIEF.md
# Memory-Mapped Countdown Tick Timer

This block is a 24-bit down-counter that produces a periodic tick for a processor core. Software programs a reload value and an operating mode through a small word-wide register bus. The counter then counts down from that value to zero and reloads, so one full period lasts reload + 1 count events. Each time the counter steps from one to zero, the block raises a sticky wrap flag and, if interrupts are enabled, drives a one-cycle interrupt pulse.

Count events come from one of two sources, chosen in the mode register. One source is every core clock cycle. The other is each rising edge of a slower reference clock, which the block samples into the core clock domain. A read-only calibration word describes the reference clock: a flag for "no reference present", a flag for "period count inexact", and the number of reference ticks in ten milliseconds.

Bus reads return data one cycle after the request. The register is selected by byte address bits 3:2 (mode at 0x0, reload at 0x4, counter at 0x8, calibration at 0xC). Address bits 1:0 are ignored.

Top module: `tick_timer`

## Requirements
- R1: After reset, the mode, reload and counter registers read as zero and the interrupt output is low.
- R2: A read request returns its data on `bus_rdata` one cycle later, and the output holds that value until the next read. Register bits with no function read as zero. The reload register keeps only bits 23:0, and the mode register keeps only bits 2:0 plus the wrap flag at bit 16.
- R3: While mode bit 0 (run) is 0, the counter holds its value.
- R4: With mode bit 2 = 1, a count event occurs on every core cycle. On a count event, a nonzero counter decrements by one, and a counter at zero loads the reload value.
- R5: With mode bit 2 = 0, the counter moves by exactly one step per rising edge of `ref_clk_in`. That edge is seen through a two-flop synchronizer and an edge detector. A reference input held steady causes no count.
- R6: A write of any data to the counter register (0x8) sets the counter to zero and clears the wrap flag.
- R7: The wrap flag (mode bit 16) is set when the counter steps from 1 to 0. A read of the mode register returns the flag and then clears it.
- R8: With mode bit 1 = 1, `irq_o` is high for exactly one core cycle after each step from 1 to 0. With mode bit 1 = 0, `irq_o` stays low. With reload N in core-clock mode, pulses are N + 1 cycles apart.
- R9: The calibration register (0xC) reads bit 31 = no-reference flag, bit 30 = skew flag and bits 23:0 = ten-millisecond count, all taken from parameters. Writes to it have no effect.
- R10: With reload zero, a running counter stays at zero, never sets the wrap flag and never raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ref_clk_in | input | 1 | Asynchronous slow reference clock |
| irq_o | output | 1 | One-cycle tick interrupt |

## Verification
Assertions inside the counter check on every cycle the following: holding while no count event occurs, decrement and reload on each event, the clearing effect of a counter write, the single-cycle width of the interrupt and its agreement with the wrap flag, staying at zero with reload zero, and that the reference edge detector never gives two adjacent pulses. Only the bench scenarios can show the behaviours that cross the bus or depend on the reference clock. These are the register map and masking, the interrupt period of reload + 1 cycles, the one step per reference edge, the flag cleared by reading, and the calibration word surviving a write.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_CALIB  = 2'd3
  } reg_sel_e;

  localparam int MODE_RUN_BIT   = 0;
  localparam int MODE_IRQ_BIT   = 1;
  localparam int MODE_SRC_BIT   = 2;
  localparam int MODE_FLAG_BIT  = 16;
  localparam int CAL_NOREF_BIT  = 31;
  localparam int CAL_SKEW_BIT   = 30;
endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  output logic pulse_o
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < CHAIN_W; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= ref_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pulse_o <= 1'b0;
    else     pulse_o <= chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  end

  // R5: a rising edge yields one isolated pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_i,
  input  logic             clear_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic wrap;
  assign wrap = count_i && !clear_i && (cur_o == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_o  <= ZERO;
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= wrap && irq_en_i;
      if (clear_i) begin
        cur_o  <= ZERO;
        flag_o <= 1'b0;
      end else begin
        if (count_i) begin
          if (cur_o == ZERO) cur_o <= reload_i;
          else               cur_o <= cur_o - ONE;
        end
        if (wrap)            flag_o <= 1'b1;
        else if (flag_clr_i) flag_o <= 1'b0;
      end
    end
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!count_i && !clear_i) |=> $stable(cur_o));
  a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
    (count_i && !clear_i && cur_o != ZERO) |=> (cur_o == $past(cur_o) - ONE));
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (count_i && !clear_i && cur_o == ZERO) |=> (cur_o == $past(reload_i)));
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cur_o == ZERO && !flag_o));
  a_r7_irq_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);
  a_r8_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  a_r10_zero_stays: assert property (@(posedge clk) disable iff (rst)
    (cur_o == ZERO && reload_i == ZERO) |=> (cur_o == ZERO && !irq_o));
endmodule

// File: rtl/tick_reg_file.sv
module tick_reg_file
  import tick_timer_pkg::*;
#(
  parameter int             DATA_W    = 32,
  parameter int             ADDR_W    = 4,
  parameter int             CNT_W     = 24,
  parameter logic           CAL_NOREF = 1'b0,
  parameter logic           CAL_SKEW  = 1'b0,
  parameter logic [CNT_W-1:0] CAL_TENMS = CNT_W'(10000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cur_i,
  input  logic              flag_i,
  output logic              run_o,
  output logic              irq_en_o,
  output logic              src_core_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cur_clr_o,
  output logic              flag_rd_clr_o
);
  reg_sel_e          sel;
  logic              wr_hit, rd_hit;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] cal_word;

  assign sel    = reg_sel_e'(bus_addr[3:2]);
  assign wr_hit = bus_valid && bus_write;
  assign rd_hit = bus_valid && !bus_write;

  assign cur_clr_o     = wr_hit && (sel == SEL_COUNT);
  assign flag_rd_clr_o = rd_hit && (sel == SEL_MODE);

  always_comb begin
    cal_word                = '0;
    cal_word[CNT_W-1:0]     = CAL_TENMS;
    cal_word[CAL_NOREF_BIT] = CAL_NOREF;
    cal_word[CAL_SKEW_BIT]  = CAL_SKEW;
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_MODE: begin
        rd_mux[MODE_RUN_BIT]  = run_o;
        rd_mux[MODE_IRQ_BIT]  = irq_en_o;
        rd_mux[MODE_SRC_BIT]  = src_core_o;
        rd_mux[MODE_FLAG_BIT] = flag_i;
      end
      SEL_RELOAD: rd_mux[CNT_W-1:0] = reload_o;
      SEL_COUNT:  rd_mux[CNT_W-1:0] = cur_i;
      SEL_CALIB:  rd_mux = cal_word;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o      <= 1'b0;
      irq_en_o   <= 1'b0;
      src_core_o <= 1'b0;
      reload_o   <= '0;
      bus_rdata  <= '0;
    end else begin
      if (wr_hit && sel == SEL_MODE) begin
        run_o      <= bus_wdata[MODE_RUN_BIT];
        irq_en_o   <= bus_wdata[MODE_IRQ_BIT];
        src_core_o <= bus_wdata[MODE_SRC_BIT];
      end
      if (wr_hit && sel == SEL_RELOAD) reload_o <= bus_wdata[CNT_W-1:0];
      if (rd_hit) bus_rdata <= rd_mux;
    end
  end

  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(bus_rdata));
  a_r9_cal_stable: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && sel == SEL_CALIB) |=> (bus_rdata[CNT_W-1:0] == CAL_TENMS));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int               DATA_W      = 32,
  parameter int               ADDR_W      = 4,
  parameter int               CNT_W       = 24,
  parameter int               SYNC_STAGES = 2,
  parameter logic             CAL_NOREF   = 1'b0,
  parameter logic             CAL_SKEW    = 1'b0,
  parameter logic [CNT_W-1:0] CAL_TENMS   = CNT_W'(10000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_clk_in,
  output logic              irq_o
);
  logic             run, irq_en, src_core, cur_clr, flag_rd_clr, flag, ref_pulse, count_ev;
  logic [CNT_W-1:0] reload, cur;

  tick_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ref_i(ref_clk_in), .pulse_o(ref_pulse)
  );

  assign count_ev = run && (src_core || ref_pulse);

  tick_reg_file #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .CAL_NOREF(CAL_NOREF), .CAL_SKEW(CAL_SKEW), .CAL_TENMS(CAL_TENMS)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cur_i(cur), .flag_i(flag),
    .run_o(run), .irq_en_o(irq_en), .src_core_o(src_core), .reload_o(reload),
    .cur_clr_o(cur_clr), .flag_rd_clr_o(flag_rd_clr)
  );

  tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .count_i(count_ev), .clear_i(cur_clr), .flag_clr_i(flag_rd_clr),
    .irq_en_i(irq_en), .reload_i(reload),
    .cur_o(cur), .flag_o(flag), .irq_o(irq_o)
  );
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ref_clk_in = 1'b0;
  logic        irq_o;

  int n_checks = 0, n_fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tick_timer #(.CAL_NOREF(1'b1), .CAL_SKEW(1'b0), .CAL_TENMS(24'h0030D4)) i_tick_timer (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_clk_in(ref_clk_in), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ref_edges(input int n);
    for (int i = 0; i < n; i++) begin
      ref_clk_in = 1; idle(6);
      ref_clk_in = 0; idle(6);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq low", {31'b0, irq_o}, 32'h0);
    rd(4'h0, d); check("R1 mode", d, 32'h0);
    rd(4'h4, d); check("R1 reload", d, 32'h0);
    rd(4'h8, d); check("R1 counter", d, 32'h0);
  endtask

  task automatic t_masking;
    logic [31:0] d;
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); check("R2 reload mask", d, 32'h00FF_FFFF);
    wr(4'h0, 32'hFFFE_FFF8);
    rd(4'h1, d); check("R2 mode unused bits", d, 32'h0);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_calib;
    logic [31:0] d;
    rd(4'hC, d); check("R9 calib word", d, 32'h8000_30D4);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, d); check("R9 calib after write", d, 32'h8000_30D4);
  endtask

  task automatic t_core_irq;
    int gap, first;
    logic [31:0] d;
    wr(4'h4, 32'd10);
    wr(4'h8, 32'h0);
    wr(4'h0, 32'h7);
    first = 0;
    while (!irq_o && first < 100) begin idle(1); first++; end
    check("R8 first irq seen", {31'b0, irq_o}, 32'h1);
    idle(1);
    check("R8 irq one cycle", {31'b0, irq_o}, 32'h0);
    gap = 1;
    while (!irq_o && gap < 100) begin idle(1); gap++; end
    check("R8/R4 irq period", gap, 32'd11);
    wr(4'h0, 32'h0);
    rd(4'h0, d); check("R7 flag set by wrap", d, 32'h0001_0000);
    rd(4'h0, d); check("R7 flag cleared by read", d, 32'h0);
  endtask

  task automatic t_no_irq;
    int seen = 0;
    logic [31:0] d;
    wr(4'h4, 32'd3);
    wr(4'h0, 32'h5);
    for (int i = 0; i < 30; i++) begin idle(1); if (irq_o) seen++; end
    wr(4'h0, 32'h0);
    check("R8 no irq when masked", seen, 32'd0);
    rd(4'h0, d); check("R7 flag without irq", d, 32'h0001_0000);
  endtask

  task automatic t_hold_and_clear;
    logic [31:0] a, b;
    wr(4'h4, 32'd50);
    wr(4'h0, 32'h5);
    idle(20);
    wr(4'h0, 32'h4);
    rd(4'h8, a);
    idle(20);
    rd(4'h8, b);
    check("R3 holds while stopped", b, a);
    check("R4 counted while running", {31'b0, (a != 0)}, 32'h1);
    wr(4'h8, 32'hDEAD_BEEF);
    rd(4'h8, b); check("R6 counter cleared", b, 32'h0);
  endtask

  task automatic t_flag_clear_by_write;
    logic [31:0] d;
    wr(4'h4, 32'd2);
    wr(4'h0, 32'h5);
    idle(10);
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h1234_5678);
    rd(4'h0, d); check("R6 flag cleared by counter write", d, 32'h0);
  endtask

  task automatic t_ref_mode;
    logic [31:0] d;
    wr(4'h4, 32'd100);
    wr(4'h8, 32'h0);
    wr(4'h0, 32'h1);
    idle(10);
    rd(4'h8, d); check("R5 no count without edge", d, 32'h0);
    ref_edges(1);
    rd(4'h8, d); check("R5 first edge loads reload", d, 32'd100);
    ref_edges(3);
    rd(4'h8, d); check("R5 one step per edge", d, 32'd97);
    ref_clk_in = 1; idle(30);
    rd(4'h8, d); check("R5 steady high no count", d, 32'd96);
    ref_clk_in = 0; idle(6);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_zero_reload;
    int seen = 0;
    logic [31:0] d;
    wr(4'h4, 32'd0);
    wr(4'h8, 32'h0);
    wr(4'h0, 32'h7);
    for (int i = 0; i < 30; i++) begin idle(1); if (irq_o) seen++; end
    check("R10 no irq with zero reload", seen, 32'd0);
    rd(4'h8, d); check("R10 counter stays zero", d, 32'h0);
    wr(4'h0, 32'h0);
    rd(4'h0, d); check("R10 no flag", d, 32'h0);
  endtask

  initial begin
    idle(4);
    rst = 0;
    idle(1);
    t_reset();
    t_masking();
    t_calib();
    t_core_irq();
    t_no_irq();
    t_hold_and_clear();
    t_flag_clear_by_write();
    t_ref_mode();
    t_zero_reload();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule